// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block sits beside the integer pipeline of a 32-bit processor and owns a private pair of result registers, hi and lo. The pipeline hands it a function code and two register operands. It runs a signed or unsigned multiply or divide over many cycles and then writes both halves of the result into hi and lo. Two move operations let software load hi or lo from a register operand, and two more read hi or lo back out.

While an iterative operation runs, the unit raises `busy`. Any recognised request that arrives in that window, whether a read, a move or a new multiply or divide, is refused with `stall`. The requester must hold the request until `stall` falls. Nothing is dropped or reordered. Multiply uses shift-and-add on operand magnitudes, and divide uses restoring division. For signed work, a sign fix-up is applied at the end.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: Function code 6'b011000 multiplies `req_s` by `req_t` as two's-complement values; the upper 32 bits of the 64-bit product land in hi and the lower 32 bits in lo.
- R2: Function code 6'b011001 forms the same 64-bit split with both operands taken as unsigned.
- R3: Function code 6'b011010 divides `req_s` by a non-zero `req_t` as signed values; lo receives the quotient truncated toward zero and hi the remainder, which carries the sign of the dividend (the most negative value divided by -1 gives lo = 32'h80000000, hi = 0).
- R4: Function code 6'b011011 divides as unsigned values, quotient to lo and remainder to hi.
- R5: A divide (either code) by zero completes normally with lo = 32'hFFFFFFFF and hi = the unmodified dividend.
- R6: With function code 6'b010000 (read hi) or 6'b010010 (read lo) requested and `stall` low, `rd_data` shows the current hi or lo in that same cycle.
- R7: Function code 6'b010001 loads hi, and 6'b010011 loads lo, from `req_s` at the clock edge that accepts it.
- R8: `busy` rises at the edge that accepts a multiply or divide and stays high for exactly 33 cycles; the new hi and lo are readable in the first cycle with `busy` low.
- R9: A read of hi or lo requested while `busy` is high raises `stall` and is not served until `busy` falls.
- R10: A multiply, divide or move requested while `busy` is high raises `stall`, leaves hi and lo untouched, and takes effect once the held request is accepted; requests complete in issue order.
- R11: After reset, hi and lo are zero and `busy` and `stall` are low.
- R12: Any other function code with `req_valid` high changes neither hi nor lo and never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk upstream |
| req_valid | input | 1 | A request is presented this cycle |
| req_func | input | 6 | Function code of the request |
| req_s | input | 32 | First register operand (dividend, multiplicand, move source) |
| req_t | input | 32 | Second register operand (divisor, multiplier) |
| rd_data | output | 32 | hi or lo, chosen by the read function code |
| busy | output | 1 | An iterative operation is in progress |
| stall | output | 1 | The presented request is refused this cycle and must be held |

## Verification
A multiply or divide accepted at edge E0 writes hi and lo at edge E0+33. A move writes at its accepting edge. A read returns data combinationally in the cycle where `stall` is low. The driver presents every request on a falling edge and holds it while `stall` is sampled high. The monitor compares `rd_data` against the scoreboard a quarter period after the falling edge, only in the cycle the read is accepted. That way each expected value is checked exactly when the interlock allows it, wherever the read lands relative to the 33-cycle window. The busy window length is measured by counting falling edges with `busy` high.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  localparam logic [5:0] FN_MUL_S = 6'b011000;
  localparam logic [5:0] FN_MUL_U = 6'b011001;
  localparam logic [5:0] FN_DIV_S = 6'b011010;
  localparam logic [5:0] FN_DIV_U = 6'b011011;
  localparam logic [5:0] FN_RD_HI = 6'b010000;
  localparam logic [5:0] FN_WR_HI = 6'b010001;
  localparam logic [5:0] FN_RD_LO = 6'b010010;
  localparam logic [5:0] FN_WR_LO = 6'b010011;

  typedef enum logic [2:0] {
    K_NONE,
    K_MUL,
    K_DIV,
    K_RDHI,
    K_RDLO,
    K_WRHI,
    K_WRLO
  } req_kind_t;

endpackage

// File: rtl/hilo_decode.sv
module hilo_decode
  import hilo_pkg::*;
(
  input  logic [5:0] func,
  output req_kind_t  kind,
  output logic       is_signed
);

  always_comb begin
    kind      = K_NONE;
    is_signed = 1'b0;
    unique case (func)
      FN_MUL_S: begin kind = K_MUL; is_signed = 1'b1; end
      FN_MUL_U: kind = K_MUL;
      FN_DIV_S: begin kind = K_DIV; is_signed = 1'b1; end
      FN_DIV_U: kind = K_DIV;
      FN_RD_HI: kind = K_RDHI;
      FN_RD_LO: kind = K_RDLO;
      FN_WR_HI: kind = K_WRHI;
      FN_WR_LO: kind = K_WRLO;
      default:  kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/hilo_iter_engine.sv
module hilo_iter_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_div,
  input  logic         start_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          running_q, running_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_q, div_d;
  logic          negq_q, negq_d;
  logic          negr_q, negr_d;
  logic [W-1:0]  acch_q, acch_d;
  logic [W-1:0]  accl_q, accl_d;
  logic [W-1:0]  opnd_q, opnd_d;

  logic [W-1:0]   mag_a, mag_b;
  logic [W:0]     msum;
  logic [W:0]     dpart;
  logic           dge;
  logic [W-1:0]   ddiff;
  logic [2*W-1:0] prod_mag, prod_fix;

  always_comb begin
    mag_a = (start_signed && opa[W-1]) ? -opa : opa;
    mag_b = (start_signed && opb[W-1]) ? -opb : opb;
    msum  = {1'b0, acch_q} + (accl_q[0] ? {1'b0, opnd_q} : '0);
    dpart = {acch_q, accl_q[W-1]};
    dge   = dpart >= {1'b0, opnd_q};
    ddiff = dpart[W-1:0] - opnd_q;
  end

  // next state
  always_comb begin
    running_d = running_q;
    done_d    = 1'b0;
    cnt_d     = cnt_q;
    div_d     = div_q;
    negq_d    = negq_q;
    negr_d    = negr_q;
    acch_d    = acch_q;
    accl_d    = accl_q;
    opnd_d    = opnd_q;
    if (start) begin
      running_d = 1'b1;
      cnt_d     = '0;
      div_d     = start_div;
      negq_d    = start_signed && (opa[W-1] ^ opb[W-1]) && (!start_div || (opb != '0));
      negr_d    = start_signed && start_div && opa[W-1];
      acch_d    = '0;
      accl_d    = mag_a;
      opnd_d    = mag_b;
    end else if (running_q) begin
      cnt_d = cnt_q + 1'b1;
      if (div_q) begin
        acch_d = dge ? ddiff : dpart[W-1:0];
        accl_d = {accl_q[W-2:0], dge};
      end else begin
        acch_d = msum[W:1];
        accl_d = {msum[0], accl_q[W-1:1]};
      end
      if (cnt_q == LAST) begin
        running_d = 1'b0;
        done_d    = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      div_q     <= 1'b0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      acch_q    <= '0;
      accl_q    <= '0;
      opnd_q    <= '0;
    end else begin
      running_q <= running_d;
      done_q    <= done_d;
      cnt_q     <= cnt_d;
      div_q     <= div_d;
      negq_q    <= negq_d;
      negr_q    <= negr_d;
      acch_q    <= acch_d;
      accl_q    <= accl_d;
      opnd_q    <= opnd_d;
    end
  end

  always_comb begin
    prod_mag = {acch_q, accl_q};
    prod_fix = negq_q ? -prod_mag : prod_mag;
    if (div_q) begin
      res_hi = negr_q ? -acch_q : acch_q;
      res_lo = negq_q ? -accl_q : accl_q;
    end else begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end
  end

  assign busy = running_q | done_q;
  assign done = done_q;

  // R8: the final iteration is followed by exactly one result cycle
  p_last_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && (cnt_q == LAST) |=> done_q && !running_q);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q && !running_q);
  // R10: a new operation never starts over one in flight
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running_q && !done_q);
  // R5: zero divisor yields an all-ones quotient
  p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && div_q && (opnd_q == '0) |-> res_lo == '1);

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [5:0]   req_func,
  input  logic [W-1:0] req_s,
  input  logic [W-1:0] req_t,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         stall
);

  req_kind_t    kind;
  logic         kind_signed;
  logic         eng_busy, eng_done;
  logic [W-1:0] eng_hi, eng_lo;
  logic         accept, known, go;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_en, lo_en;

  hilo_decode u_dec (
    .func      (req_func),
    .kind      (kind),
    .is_signed (kind_signed)
  );

  assign known  = (kind != K_NONE);
  assign accept = req_valid && known && !eng_busy;
  assign go     = accept && ((kind == K_MUL) || (kind == K_DIV));

  hilo_iter_engine #(.W(W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (go),
    .start_div    (kind == K_DIV),
    .start_signed (kind_signed),
    .opa          (req_s),
    .opb          (req_t),
    .busy         (eng_busy),
    .done         (eng_done),
    .res_hi       (eng_hi),
    .res_lo       (eng_lo)
  );

  // next state with explicit enables
  always_comb begin
    hi_en = 1'b0;
    lo_en = 1'b0;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (eng_done) begin
      hi_en = 1'b1;
      lo_en = 1'b1;
      hi_d  = eng_hi;
      lo_d  = eng_lo;
    end else if (accept && (kind == K_WRHI)) begin
      hi_en = 1'b1;
      hi_d  = req_s;
    end else if (accept && (kind == K_WRLO)) begin
      lo_en = 1'b1;
      lo_d  = req_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign rd_data = (kind == K_RDLO) ? lo_q : hi_q;
  assign busy    = eng_busy;
  assign stall   = req_valid && known && eng_busy;

  // R10: nothing touches hi/lo while an operation is in flight
  p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && !eng_done |=> $stable(hi_q) && $stable(lo_q));
  // R7: an accepted move into hi takes the operand
  p_move_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (kind == K_WRHI) |=> hi_q == $past(req_s));
  // R12: without a request or an operation, hi/lo hold
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy && !req_valid |=> $stable(hi_q) && $stable(lo_q));
  // R9: refusal only while busy
  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);

endmodule

// File: tb/sim_hilo_muldiv_unit.sv
module sim_hilo_muldiv_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] F_MS = 6'b011000, F_MU = 6'b011001;
  localparam logic [5:0] F_DS = 6'b011010, F_DU = 6'b011011;
  localparam logic [5:0] F_RH = 6'b010000, F_WH = 6'b010001;
  localparam logic [5:0] F_RL = 6'b010010, F_WL = 6'b010011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_func;
  logic [31:0] req_s, req_t;
  logic [31:0] rd_data;
  logic        busy, stall;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hilo_muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_func(req_func),
    .req_s(req_s), .req_t(req_t), .rd_data(rd_data), .busy(busy), .stall(stall)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] f, input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_s = s; req_t = t;
    #1;
    while (stall) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] f, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(f, 32'h0, 32'h0);
  endtask

  // monitor: compare accepted reads against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && req_valid && !stall && (req_func == F_RH || req_func == F_RL)) begin
        if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", rd_data, 32'h0);
        else chk(rd_data === exp_q[0], tag_q[0], rd_data, exp_q[0]);
        if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      end
    end
  end

  function automatic logic [63:0] e_smul(input logic [31:0] s, input logic [31:0] t);
    longint a, b;
    a = longint'($signed(s)); b = longint'($signed(t));
    return 64'(a * b);
  endfunction

  function automatic logic [63:0] e_umul(input logic [31:0] s, input logic [31:0] t);
    return {32'h0, s} * {32'h0, t};
  endfunction

  // returns {hi, lo}
  function automatic logic [63:0] e_sdiv(input logic [31:0] s, input logic [31:0] t);
    longint a, b;
    if (t == 0) return {s, 32'hFFFFFFFF};
    a = longint'($signed(s)); b = longint'($signed(t));
    return {32'(a % b), 32'(a / b)};
  endfunction

  function automatic logic [63:0] e_udiv(input logic [31:0] s, input logic [31:0] t);
    if (t == 0) return {s, 32'hFFFFFFFF};
    return {s % t, s / t};
  endfunction

  task automatic run_and_read(input logic [5:0] f, input logic [31:0] s, input logic [31:0] t,
                              input logic [63:0] e, input string tag);
    issue(f, s, t);
    rd(F_RH, e[63:32], {tag, " hi"});
    rd(F_RL, e[31:0], {tag, " lo"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_func = 6'h0; req_s = 0; req_t = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11
    chk(busy == 1'b0, "R11 busy after reset", {31'h0, busy}, 32'h0);
    chk(stall == 1'b0, "R11 stall after reset", {31'h0, stall}, 32'h0);
    rd(F_RH, 32'h0, "R11 hi reset");
    rd(F_RL, 32'h0, "R11 lo reset");

    // R7 / R6
    issue(F_WH, 32'h1234_5678, 32'h0);
    issue(F_WL, 32'hCAFE_0001, 32'h0);
    rd(F_RH, 32'h1234_5678, "R7 R6 move hi");
    rd(F_RL, 32'hCAFE_0001, "R7 R6 move lo");

    // R12
    issue(6'b100000, 32'hDEAD_BEEF, 32'h1);
    chk(stall == 1'b0, "R12 no stall", {31'h0, stall}, 32'h0);
    issue(6'b000000, 32'hDEAD_BEEF, 32'h1);
    rd(F_RH, 32'h1234_5678, "R12 hi unchanged");
    rd(F_RL, 32'hCAFE_0001, "R12 lo unchanged");

    // R1
    run_and_read(F_MS, 32'd7, 32'hFFFF_FFFD, e_smul(32'd7, 32'hFFFF_FFFD), "R1 7*-3");
    run_and_read(F_MS, 32'h8000_0000, 32'h8000_0000, e_smul(32'h8000_0000, 32'h8000_0000), "R1 min*min");
    run_and_read(F_MS, 32'h0001_2345, 32'h0000_6789, e_smul(32'h0001_2345, 32'h0000_6789), "R1 pos*pos");
    // R2
    run_and_read(F_MU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, e_umul(32'hFFFF_FFFF, 32'hFFFF_FFFF), "R2 max*max");
    run_and_read(F_MU, 32'h8000_0001, 32'd3, e_umul(32'h8000_0001, 32'd3), "R2 big*3");
    // R3
    run_and_read(F_DS, 32'hFFFF_FFF9, 32'd2, e_sdiv(32'hFFFF_FFF9, 32'd2), "R3 -7/2");
    run_and_read(F_DS, 32'd7, 32'hFFFF_FFFE, e_sdiv(32'd7, 32'hFFFF_FFFE), "R3 7/-2");
    run_and_read(F_DS, 32'h8000_0000, 32'hFFFF_FFFF, {32'h0, 32'h8000_0000}, "R3 min/-1");
    // R4
    run_and_read(F_DU, 32'hFFFF_FFFF, 32'd10, e_udiv(32'hFFFF_FFFF, 32'd10), "R4 max/10");
    run_and_read(F_DU, 32'd5, 32'd9, e_udiv(32'd5, 32'd9), "R4 5/9");
    // R5
    run_and_read(F_DS, 32'hFFFF_FF00, 32'd0, {32'hFFFF_FF00, 32'hFFFF_FFFF}, "R5 signed /0");
    run_and_read(F_DU, 32'h0BAD_F00D, 32'd0, {32'h0BAD_F00D, 32'hFFFF_FFFF}, "R5 unsigned /0");

    // R8: busy length and immediate read
    issue(F_MU, 32'd6, 32'd7);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == 33, "R8 busy cycles", 32'(n), 32'd33);
    rd(F_RL, 32'd42, "R8 result after busy");

    // R9: read while busy stalls, then returns the new result
    issue(F_MS, 32'hFFFF_FFFF, 32'd5);
    #1;
    req_valid = 1'b1; req_func = F_RL;
    #1;
    chk(stall == 1'b1, "R9 stall on read while busy", {31'h0, stall}, 32'h1);
    req_valid = 1'b0;
    rd(F_RL, 32'hFFFF_FFFB, "R9 read after stall");
    rd(F_RH, 32'hFFFF_FFFF, "R9 hi after stall");

    // R10: queued operations complete in order
    issue(F_MU, 32'd100, 32'd100);
    #1;
    req_valid = 1'b1; req_func = F_WH; req_s = 32'h5555_AAAA;
    #1;
    chk(stall == 1'b1, "R10 stall on move while busy", {31'h0, stall}, 32'h1);
    req_valid = 1'b0;
    issue(F_DU, 32'd100, 32'd7);
    issue(F_WH, 32'h5555_AAAA, 32'h0);
    rd(F_RH, 32'h5555_AAAA, "R10 move after divide");
    rd(F_RL, 32'd14, "R10 divide not dropped");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule